// File: doc/BRIEF.md
# Jittered Sampling Switch

This block models a synchronous computing element inside a loosely timed system. It works in back-to-back cycles. Each cycle opens by latching the boolean input. It then runs for a pseudo-random number of clock ticks inside an inclusive window [T_MIN, T_MAX], and it closes by driving the latched value onto the output. The next cycle opens on the same edge that closes the current one. A free-running seeded LFSR picks each cycle length, so the element behaves like a periodic task with bounded jitter.

The effect of interest is timing at the boundary. The input is seen only at cycle boundaries, so a level that changes and changes back between two boundaries never reaches the output. A level that is held long enough always arrives, with a lag bounded by one full cycle of waiting plus one full cycle of processing. Designers place the block in a signal path to reproduce these lags and pulse losses in cycle-accurate form.

The state machine has two states. `SW_IDLE` is the state held in reset. `SW_BUSY` counts down the current cycle. The transitions are:

- launch: `SW_IDLE` to `SW_BUSY` on the first edge after reset, which latches the input and loads the first length.
- count: `SW_BUSY` to `SW_BUSY` while more than one tick remains.
- handoff: `SW_BUSY` to `SW_BUSY` on the last tick. On this edge the output takes the latched value, the input is latched again and a new length is loaded.
- reset: any state to `SW_IDLE` while `rst_n` is low.

Top module: `jitter_sampler`

## Requirements
- R1: While `rst_n` is low (synchronous, active low) `dout` is 0 on the following edge. After release, the first cycle launches on the first rising edge, and `dout` stays 0 until that cycle ends.
- R2: Every cycle lasts between T_MIN and T_MAX clock edges inclusive. The length comes from an LFSR loaded with `seed` during reset, so two instances with equal seeds and inputs produce identical outputs.
- R3: The value on `din` at a cycle's opening edge is the value driven on `dout` at that cycle's closing edge. A `din` level that begins and ends strictly between two opening edges is lost.
- R4: `dout` changes only on the closing edge of a cycle.
- R5: A `din` level held for at least T_MAX consecutive edges always appears on `dout`.
- R6: Count as edge 1 the first edge at which `din` holds a new level, and assume the level is held for at least T_MAX edges. Then `dout` takes that level after edge k, with T_MIN+1 <= k <= 2*T_MAX. This holds for rising and falling changes alike.
- R7: Once `dout` changes, it keeps its new level for at least T_MIN edges.
- R8: With T_MIN equal to T_MAX = T, `din` is sampled on the first edge after reset and on every T-th edge after it. After edge n (edge 0 being the first), `dout` equals the `din` sampled at edge T*(floor(n/T)-1), or 0 when n < T.
- R9: An all-zero `seed` still gives cycles inside [T_MIN, T_MAX] and satisfies R5 to R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock; one tick of cycle time |
| rst_n | input | 1 | Synchronous reset, active low; also loads the seed |
| seed | input | LFSR_W | Initial LFSR state; zero selects a fixed nonzero fallback |
| din | input | 1 | Boolean input level |
| dout | output | 1 | Level latched at the previous cycle opening |

## Verification
The bench builds four copies of the block. One copy uses T_MIN = T_MAX = 4, which fixes the period and makes every output edge exactly predictable; it checks the sampling instants, glitch loss and reset against a vector table. Two copies with the window [3, 6] and equal seeds exercise the power-of-two reduction of the LFSR value and the equal-seed repeatability. A fourth copy with window [3, 7] and a zero seed exercises the general modulo reduction and the fallback seed. Short windows keep the lag bounds small, so many pulse phases are covered within a few hundred edges.

// File: rtl/jsw_pkg.sv
package jsw_pkg;

    // Cycle controller states
    typedef enum logic [1:0] {
        SW_IDLE = 2'd0,   // held in reset, launches on first free edge
        SW_BUSY = 2'd1    // counting down the current cycle
    } sw_state_e;

endpackage

// File: rtl/jsw_lfsr.sv
// Galois LFSR, stepped once per cycle opening, seeded during reset.
module jsw_lfsr #(
    parameter int             W    = 16,
    parameter logic [W-1:0]   TAPS = 16'hB400
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] seed,
    input  logic         step,
    output logic [W-1:0] value
);

    localparam logic [W-1:0] FALLBACK = W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= (seed == '0) ? FALLBACK : seed;
        end else if (step) begin
            value <= {1'b0, value[W-1:1]} ^ (value[0] ? TAPS : '0);
        end
    end

endmodule

// File: rtl/jsw_len_map.sv
// Folds a raw LFSR word into the inclusive length window.
module jsw_len_map #(
    parameter int W     = 16,
    parameter int T_MIN = 27,
    parameter int T_MAX = 33,
    parameter int CW    = 6
) (
    input  logic [W-1:0]  rnd,
    output logic [CW-1:0] len
);

    localparam int SPAN     = T_MAX - T_MIN + 1;
    localparam bit SPAN_POW = (SPAN & (SPAN - 1)) == 0;

    generate
        if (SPAN_POW) begin : g_mask
            // window width is a power of two: low bits suffice
            assign len = CW'(T_MIN) + CW'(rnd & W'(SPAN - 1));
        end else begin : g_mod
            // general window: remainder after division by the width
            assign len = CW'(T_MIN) + CW'(rnd % W'(SPAN));
        end
    endgenerate

endmodule

// File: rtl/jsw_fsm.sv
// Cycle controller: latches the input, counts the cycle, hands off the value.
module jsw_fsm
    import jsw_pkg::*;
#(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          din,
    input  logic [CW-1:0] len,
    output logic          dout,
    output logic          handoff,
    output logic          cyc_start
);

    sw_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          held_q;

    assign handoff   = (state_q == SW_BUSY) && (cnt_q == CW'(1));
    assign cyc_start = (state_q == SW_IDLE) || handoff;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SW_IDLE: state_d = SW_BUSY;   // launch
            SW_BUSY: state_d = SW_BUSY;   // count or handoff
            default: state_d = SW_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SW_IDLE;
        else        state_q <= state_d;
    end

    // cycle counter and latched sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            held_q <= 1'b0;
        end else if (cyc_start) begin
            cnt_q  <= len;
            held_q <= din;
        end else if (state_q == SW_BUSY) begin
            cnt_q  <= cnt_q - CW'(1);
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n)       dout <= 1'b0;
        else if (handoff) dout <= held_q;
    end

endmodule

// File: rtl/jitter_sampler.sv
// Jittered sampling switch: top level.
module jitter_sampler #(
    parameter int                 T_MIN     = 27,
    parameter int                 T_MAX     = 33,
    parameter int                 LFSR_W    = 16,
    parameter logic [LFSR_W-1:0]  LFSR_TAPS = 16'hB400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LFSR_W-1:0] seed,
    input  logic              din,
    output logic              dout
);

    localparam int CW = $clog2(T_MAX + 1);

    logic [LFSR_W-1:0] rnd;
    logic [CW-1:0]     cyc_len;
    logic              handoff;
    logic              cyc_start;

    jsw_lfsr #(
        .W    (LFSR_W),
        .TAPS (LFSR_TAPS)
    ) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .seed  (seed),
        .step  (cyc_start),
        .value (rnd)
    );

    jsw_len_map #(
        .W     (LFSR_W),
        .T_MIN (T_MIN),
        .T_MAX (T_MAX),
        .CW    (CW)
    ) u_len (
        .rnd (rnd),
        .len (cyc_len)
    );

    jsw_fsm #(
        .CW (CW)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .din       (din),
        .len       (cyc_len),
        .dout      (dout),
        .handoff   (handoff),
        .cyc_start (cyc_start)
    );

endmodule

// File: rtl/jsw_checker.sv
// Temporal checks for jitter_sampler, attached by bind.
module jsw_checker #(
    parameter int T_MIN = 27,
    parameter int T_MAX = 33,
    parameter int CW    = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          dout,
    input logic [CW-1:0] cyc_len,
    input logic          handoff
);

    localparam int GW = $clog2(T_MIN + 1) + 1;

    logic [GW-1:0] gap;
    logic          prev;

    // edges elapsed since the last output change, saturating at T_MIN
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap  <= '0;
            prev <= 1'b0;
        end else begin
            prev <= dout;
            if (dout != prev)            gap <= GW'(1);
            else if (gap < GW'(T_MIN))   gap <= gap + GW'(1);
        end
    end

    // R1: output is clear on the first edge after reset
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !dout);

    // R2: every chosen length lies inside the window
    a_r2_len_window: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_len >= CW'(T_MIN)) && (cyc_len <= CW'(T_MAX)));

    // R4: output moves only on a cycle-closing edge
    a_r4_edge_at_handoff: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dout) |-> $past(handoff));

    // R7: a new output level persists at least T_MIN edges
    a_r7_min_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (dout != prev) |-> (gap >= GW'(T_MIN)));

endmodule

bind jitter_sampler jsw_checker #(
    .T_MIN (T_MIN),
    .T_MAX (T_MAX),
    .CW    (CW)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .dout    (dout),
    .cyc_len (cyc_len),
    .handoff (handoff)
);

// File: tb/jitter_sampler_test.sv
`timescale 1ns/1ps
module jitter_sampler_test;

    localparam int FX_T   = 4;
    localparam int JA_MIN = 3;
    localparam int JA_MAX = 6;
    localparam int JZ_MIN = 3;
    localparam int JZ_MAX = 7;

    // {din driven before edge n, dout expected after edge n}
    localparam logic [1:0] VEC [0:23] = '{
        2'b10, 2'b00, 2'b00, 2'b00, 2'b01, 2'b11, 2'b11, 2'b11,
        2'b00, 2'b10, 2'b10, 2'b10, 2'b10, 2'b00, 2'b00, 2'b00,
        2'b01, 2'b01, 2'b01, 2'b01, 2'b10, 2'b00, 2'b00, 2'b00
    };

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    logic din_f = 1'b0;
    logic din_j = 1'b0;
    logic dout_f, dout_a, dout_b, dout_z;
    int   checks = 0;
    int   errors = 0;

    always #4 clk = ~clk;

    jitter_sampler #(.T_MIN(FX_T), .T_MAX(FX_T)) uut (
        .clk(clk), .rst_n(rst_n), .seed(16'h1234), .din(din_f), .dout(dout_f));
    jitter_sampler #(.T_MIN(JA_MIN), .T_MAX(JA_MAX)) uut_a (
        .clk(clk), .rst_n(rst_n), .seed(16'hACE1), .din(din_j), .dout(dout_a));
    jitter_sampler #(.T_MIN(JA_MIN), .T_MAX(JA_MAX)) uut_b (
        .clk(clk), .rst_n(rst_n), .seed(16'hACE1), .din(din_j), .dout(dout_b));
    jitter_sampler #(.T_MIN(JZ_MIN), .T_MAX(JZ_MAX)) uut_z (
        .clk(clk), .rst_n(rst_n), .seed(16'h0000), .din(din_j), .dout(dout_z));

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int lo, input int hi);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d..%0d", req, what, act, lo, hi);
        end
    endtask

    task automatic summary;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // one high pulse of w edges followed by g low edges on the jittered copies
    task automatic pulse(input int w, input int g);
        int ra = 0, fa = 0, rz = 0, fz = 0, mism = 0;
        for (int k = 1; k <= w + g; k++) begin
            din_j = (k <= w);
            @(posedge clk);
            @(negedge clk);
            if (dout_a && ra == 0) ra = k;
            if (!dout_a && ra != 0 && fa == 0) fa = k;
            if (dout_z && rz == 0) rz = k;
            if (!dout_z && rz != 0 && fz == 0) fz = k;
            if (dout_a !== dout_b) mism++;
        end
        check(ra != 0, "R5", "pulse reached output (a)", ra, 1, 2*JA_MAX);
        check(ra >= JA_MIN+1 && ra <= 2*JA_MAX, "R6", "rise lag (a)", ra, JA_MIN+1, 2*JA_MAX);
        check(fa-w >= JA_MIN+1 && fa-w <= 2*JA_MAX, "R6", "fall lag (a)", fa-w, JA_MIN+1, 2*JA_MAX);
        check(fa-ra >= JA_MIN, "R7", "high time (a)", fa-ra, JA_MIN, w+g);
        check(mism == 0, "R2", "equal seeds diverged", mism, 0, 0);
        check(rz != 0, "R9 R5", "pulse reached output (z)", rz, 1, 2*JZ_MAX);
        check(rz >= JZ_MIN+1 && rz <= 2*JZ_MAX, "R9 R6", "rise lag (z)", rz, JZ_MIN+1, 2*JZ_MAX);
        check(fz-w >= JZ_MIN+1 && fz-w <= 2*JZ_MAX, "R9 R6", "fall lag (z)", fz-w, JZ_MIN+1, 2*JZ_MAX);
        check(fz-rz >= JZ_MIN, "R9 R7", "high time (z)", fz-rz, JZ_MIN, w+g);
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog all requirements actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(dout_f == 1'b0 && dout_a == 1'b0 && dout_z == 1'b0, "R1", "output in reset",
              {dout_f, dout_a, dout_z}, 0, 0);

        // fixed-period vector table
        rst_n = 1'b1;
        din_f = VEC[0][1];
        for (int n = 0; n < 24; n++) begin
            @(posedge clk);
            @(negedge clk);
            check(dout_f == VEC[n][0],
                  (n < FX_T) ? "R1" : (n >= 8 && n <= 11) ? "R3" : (n % FX_T == 0) ? "R4" : "R8",
                  $sformatf("fixed dout after edge %0d", n), dout_f, VEC[n][0], VEC[n][0]);
            if (n < 23) din_f = VEC[n+1][1];
        end

        // held high: appears after the next period boundary
        din_f = 1'b1;
        repeat (8) begin @(posedge clk); @(negedge clk); end
        check(dout_f == 1'b1, "R8", "fixed dout after held high", dout_f, 1, 1);

        // reset while output is high
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(dout_f == 1'b0, "R1", "reset clears high output", dout_f, 0, 0);
        din_f = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;

        // jittered pulses at many phases
        pulse(7, 18);
        pulse(8, 19);
        pulse(10, 20);
        pulse(7, 21);
        pulse(9, 22);
        pulse(12, 23);

        summary();
        $finish;
    end

endmodule